// File: doc/BRIEF.md
# Multi-Mode Parameter Slew Engine

This block keeps a bank of 64 ramping coefficients for an audio signal processor. Each location has a target word and a current value. A control path writes the target words. The datapath reads the current values. Once per audio frame a pulse on `frame_start` begins a sweep. During the sweep one shared arithmetic unit visits the locations in order, one per clock, and moves each current value one step toward its effective target. Each location uses the curve that the top bits of its own target word select: a fixed linear step, a step proportional to the current value (constant dB), a step proportional to the remaining distance (RC-style), or a constant-time ramp whose per-frame increment is computed once.

A global `mute` input forces the effective target of every non-constant-time location to zero. The stored target words are not modified, so releasing mute makes every location ramp back to its earlier target. Constant-time locations do not respond to mute. After reset every location is a linear ramp with time constant 5, resting at 1.0.

Top module: `param_slew_engine`

## Requirements
- R1: While and after synchronous reset, every current value is 1.0 (0x0800000) and every target word is linear, time constant 5, data 1.0. A sweep that runs with no writes therefore leaves every value at 1.0.
- R2: A `frame_start` seen while idle starts a sweep. The sweep visits location 0 in the clock after the start edge and then one location per clock up to 63. `sweep_done` is high for exactly one clock, and it is first seen 65 clocks after the start edge. A `frame_start` seen while a sweep is running is ignored.
- R3: `rd_data` gives the current value of `rd_addr` one clock after the address is sampled.
- R4: Target word fields: bits 33:32 select the curve (00 linear, 01 constant dB, 10 RC-style, 11 constant time). Bits 31:28 hold the control field. Bits 27:0 hold two's-complement data with 23 fractional bits. A write takes effect at its clock edge. If a write lands in the same cycle that the sweep visits that location, the visit uses the earlier word.
- R5: A linear step for time constant t is M[t mod 3] >> (t div 3), where M = 25891, 20550, 16311.
- R6: A constant-dB step is |current| >> (t+4), with a minimum of 1.
- R7: An RC-style step is |target-current| >> (t+4), with a minimum of 1.
- R8: A value never passes its effective target. If the remaining distance is no larger than the step, the value becomes the target. A value that equals its target stays unchanged.
- R9: Constant-time words: bit 31 is an update flag, bits 30:28 hold n, and bits 27:12 hold 16-bit data with 14 fractional bits. The effective target is that data sign-extended and shifted left by 9. Bits 11:0 are ignored.
- R10: A constant-time visit with the flag set stores the magnitude max(|target-current| >> (n+6), 1), or 0 if the distance is 0. The same visit clears the flag and steps by the new magnitude. A visit with the flag clear steps by the stored magnitude, which is 0 after reset.
- R11: While `mute` is high, the effective target of every non-constant-time location is 0. The stored words are kept, so each location returns to its earlier target after `mute` is released. Constant-time locations ignore `mute`.
- R12: If a host write and a flag clear by the sweep hit the same location in one cycle, the host write wins in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Starts a sweep of all locations |
| mute | input | 1 | Global mute of non-constant-time targets |
| wr_en | input | 1 | Target word write strobe |
| wr_addr | input | 6 | Location to write |
| wr_data | input | 34 | Target word |
| rd_addr | input | 6 | Location to read |
| rd_data | output | 28 | Current value, registered |
| sweep_done | output | 1 | One-clock pulse when a sweep completes |

## Verification
Two functions can fall in the same cycle. One is the host target write. The other is the sweep visit, including its clearing of the constant-time update flag, when both address the same location. The bench provokes this by counting clocks from a `frame_start`. It writes location 6 in the exact cycle that the sweep visits it: first replacing a flagged word with a different flagged word, then starting a second sweep pulse inside the same sweep. It judges the outcome from the values read out one and two frames later. Those values show that the visit used the old word and that the new word kept its flag.

// File: rtl/slew_pkg.sv
package slew_pkg;

    localparam int DATA_W = 28;
    localparam int CTL_W  = 4;
    localparam int WORD_W = 2 + CTL_W + DATA_W;
    localparam int CT_DATA_W = 16;
    localparam int CT_SHL    = 9;

    typedef enum logic [1:0] {
        RAMP_LIN = 2'b00,
        RAMP_DB  = 2'b01,
        RAMP_RC  = 2'b10,
        RAMP_CT  = 2'b11
    } ramp_e;

    typedef struct packed {
        ramp_e             kind;
        logic [CTL_W-1:0]  ctl;
        logic [DATA_W-1:0] data;
    } tword_t;

    localparam logic [DATA_W-1:0] UNITY = 28'h0800000;
    localparam tword_t TWORD_RESET = '{kind: RAMP_LIN, ctl: 4'd5, data: UNITY};

    // Linear step: a three-entry mantissa, halved every three time-constant units.
    function automatic logic [DATA_W:0] lin_step(input logic [CTL_W-1:0] tc);
        logic [DATA_W:0] mant;
        case (tc % 4'd3)
            4'd0:    mant = 29'd25891;
            4'd1:    mant = 29'd20550;
            default: mant = 29'd16311;
        endcase
        return mant >> (tc / 4'd3);
    endfunction

    function automatic logic [DATA_W-1:0] ct_to_fixed(input logic [CT_DATA_W-1:0] d);
        return {{(DATA_W-CT_DATA_W-CT_SHL){d[CT_DATA_W-1]}}, d, {CT_SHL{1'b0}}};
    endfunction

endpackage

// File: rtl/slew_sweep_ctrl.sv
module slew_sweep_ctrl
    import slew_pkg::*;
#(
    parameter int NUM_LOC = 64,
    localparam int IDX_W = $clog2(NUM_LOC)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_start,
    output logic             busy,
    output logic [IDX_W-1:0] idx,
    output logic             done
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_LOC - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            idx  <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (busy) begin
                if (idx == LAST) begin
                    busy <= 1'b0;
                    idx  <= '0;
                    done <= 1'b1;
                end else begin
                    idx <= idx + 1'b1;
                end
            end else if (frame_start) begin
                busy <= 1'b1;
                idx  <= '0;
            end
        end
    end

    // R2: an idle start begins at location 0
    a_r2_start_from_zero: assert property (@(posedge clk) disable iff (rst)
        (frame_start && !busy) |=> (busy && idx == '0));

    // R2: the last visit ends the sweep with a done pulse
    a_r2_last_then_done: assert property (@(posedge clk) disable iff (rst)
        (busy && idx == LAST) |=> (!busy && done));

    // R2: done lasts a single clock
    a_r2_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R2: a running sweep advances by exactly one location
    a_r2_advance_one: assert property (@(posedge clk) disable iff (rst)
        (busy && idx != LAST) |=> (busy && idx == $past(idx) + 1'b1));

endmodule

// File: rtl/slew_bank.sv
module slew_bank
    import slew_pkg::*;
#(
    parameter int NUM_LOC = 64,
    localparam int IDX_W = $clog2(NUM_LOC)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_addr,
    input  tword_t            wr_word,
    input  logic              vis_en,
    input  logic [IDX_W-1:0]  vis_idx,
    input  logic [DATA_W-1:0] vis_cur_d,
    input  logic [DATA_W-1:0] vis_mag_d,
    input  logic              vis_clr,
    output tword_t            vis_word,
    output logic [DATA_W-1:0] vis_cur,
    output logic [DATA_W-1:0] vis_mag,
    input  logic [IDX_W-1:0]  rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    tword_t            tgt_q [NUM_LOC];
    logic [DATA_W-1:0] cur_q [NUM_LOC];
    logic [DATA_W-1:0] mag_q [NUM_LOC];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_LOC; i++) begin
                tgt_q[i] <= TWORD_RESET;
                cur_q[i] <= UNITY;
                mag_q[i] <= '0;
            end
            rd_data <= UNITY;
        end else begin
            rd_data <= cur_q[rd_addr];
            if (vis_en) begin
                cur_q[vis_idx] <= vis_cur_d;
                mag_q[vis_idx] <= vis_mag_d;
                if (vis_clr) begin
                    tgt_q[vis_idx].ctl[CTL_W-1] <= 1'b0;
                end
            end
            // host write is last so it overrides a same-cycle flag clear
            if (wr_en) begin
                tgt_q[wr_addr] <= wr_word;
            end
        end
    end

    assign vis_word = tgt_q[vis_idx];
    assign vis_cur  = cur_q[vis_idx];
    assign vis_mag  = mag_q[vis_idx];

    // R10: an unopposed flag clear removes the flag
    a_r10_flag_cleared: assert property (@(posedge clk) disable iff (rst)
        (vis_en && vis_clr && !(wr_en && wr_addr == vis_idx))
        |=> !tgt_q[$past(vis_idx)].ctl[CTL_W-1]);

    // R12: a host write lands intact even against a flag clear
    a_r12_write_wins: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (tgt_q[$past(wr_addr)] == $past(wr_word)));

endmodule

// File: rtl/slew_step_unit.sv
module slew_step_unit
    import slew_pkg::*;
#(
    parameter int SHIFT_BASE = 4,
    parameter int CT_BASE    = 6
) (
    input  logic              active,
    input  logic              mute,
    input  tword_t            word,
    input  logic [DATA_W-1:0] cur,
    input  logic [DATA_W-1:0] mag,
    output logic [DATA_W-1:0] nxt_cur,
    output logic [DATA_W-1:0] nxt_mag,
    output logic              clr_flag
);

    logic [DATA_W-1:0]        eff;
    logic signed [DATA_W:0]   diff;
    logic [DATA_W:0]          adiff;
    logic [DATA_W-1:0]        acur;
    logic [DATA_W:0]          step;
    logic [DATA_W:0]          ct_mag;
    logic [5:0]               sh_tc;
    logic [5:0]               sh_ct;

    always_comb begin
        if (word.kind == RAMP_CT) begin
            eff = ct_to_fixed(word.data[DATA_W-1 -: CT_DATA_W]);
        end else if (mute) begin
            eff = '0;
        end else begin
            eff = word.data;
        end
    end

    always_comb begin
        diff  = $signed({eff[DATA_W-1], eff}) - $signed({cur[DATA_W-1], cur});
        adiff = diff[DATA_W] ? (~diff + 1'b1) : diff;
        acur  = cur[DATA_W-1] ? (~cur + 1'b1) : cur;
        sh_tc = 6'(word.ctl) + 6'(SHIFT_BASE);
        sh_ct = 6'(word.ctl[CTL_W-2:0]) + 6'(CT_BASE);
    end

    always_comb begin
        nxt_mag  = mag;
        clr_flag = 1'b0;
        ct_mag   = adiff >> sh_ct;
        if (ct_mag == '0 && adiff != '0) begin
            ct_mag = 29'd1;
        end
        case (word.kind)
            RAMP_LIN: step = lin_step(word.ctl);
            RAMP_DB: begin
                step = {1'b0, acur} >> sh_tc;
                if (step == '0) step = 29'd1;
            end
            RAMP_RC: begin
                step = adiff >> sh_tc;
                if (step == '0) step = 29'd1;
            end
            default: begin
                if (word.ctl[CTL_W-1]) begin
                    step     = ct_mag;
                    nxt_mag  = ct_mag[DATA_W-1:0];
                    clr_flag = 1'b1;
                end else begin
                    step = {1'b0, mag};
                end
            end
        endcase
    end

    always_comb begin
        if (adiff <= step) begin
            nxt_cur = eff;
        end else if (diff[DATA_W]) begin
            nxt_cur = cur - step[DATA_W-1:0];
        end else begin
            nxt_cur = cur + step[DATA_W-1:0];
        end
    end

    // R8: the new value lies between the old value and the effective target
    always_comb begin
        if (active) begin
            a_r8_no_overshoot: assert (diff[DATA_W]
                ? ($signed(nxt_cur) >= $signed(eff) && $signed(nxt_cur) <= $signed(cur))
                : ($signed(nxt_cur) <= $signed(eff) && $signed(nxt_cur) >= $signed(cur)));
        end
    end

endmodule

// File: rtl/param_slew_engine.sv
module param_slew_engine
    import slew_pkg::*;
#(
    parameter int NUM_LOC    = 64,
    parameter int SHIFT_BASE = 4,
    parameter int CT_BASE    = 6,
    localparam int IDX_W = $clog2(NUM_LOC)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start,
    input  logic              mute,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              sweep_done
);

    logic              busy;
    logic [IDX_W-1:0]  vis_idx;
    tword_t            vis_word;
    logic [DATA_W-1:0] vis_cur;
    logic [DATA_W-1:0] vis_mag;
    logic [DATA_W-1:0] nxt_cur;
    logic [DATA_W-1:0] nxt_mag;
    logic              clr_flag;

    slew_sweep_ctrl #(.NUM_LOC(NUM_LOC)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .busy        (busy),
        .idx         (vis_idx),
        .done        (sweep_done)
    );

    slew_bank #(.NUM_LOC(NUM_LOC)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_word   (tword_t'(wr_data)),
        .vis_en    (busy),
        .vis_idx   (vis_idx),
        .vis_cur_d (nxt_cur),
        .vis_mag_d (nxt_mag),
        .vis_clr   (clr_flag),
        .vis_word  (vis_word),
        .vis_cur   (vis_cur),
        .vis_mag   (vis_mag),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data)
    );

    slew_step_unit #(.SHIFT_BASE(SHIFT_BASE), .CT_BASE(CT_BASE)) u_step (
        .active   (busy),
        .mute     (mute),
        .word     (vis_word),
        .cur      (vis_cur),
        .mag      (vis_mag),
        .nxt_cur  (nxt_cur),
        .nxt_mag  (nxt_mag),
        .clr_flag (clr_flag)
    );

endmodule

// File: tb/param_slew_engine_bench.sv
module param_slew_engine_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_start = 1'b0;
    logic        mute = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [33:0] wr_data = '0;
    logic [5:0]  rd_addr = '0;
    logic [27:0] rd_data;
    logic        sweep_done;

    int vectors = 0;
    int misses  = 0;

    always #5 clk = ~clk;

    param_slew_engine u_param_slew_engine (
        .clk(clk), .rst(rst), .frame_start(frame_start), .mute(mute),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .sweep_done(sweep_done)
    );

    // ---------------- behavioural reference ----------------
    logic [33:0] m_tgt [64];
    longint      m_cur [64];
    longint      m_mag [64];
    bit          m_busy;
    int          m_idx;
    bit          m_done;
    longint      m_rd;

    function automatic longint sx28(input logic [27:0] v);
        logic signed [27:0] s;
        s = v;
        return longint'(s);
    endfunction

    function automatic void model_step(input logic [33:0] w, input longint cur,
                                       input longint mag, input bit mu,
                                       output longint ncur, output longint nmag,
                                       output bit clr);
        longint eff, diff, ad, st, ac;
        logic signed [15:0] d16;
        int kind, tc;
        longint mant [3];
        mant[0] = 25891; mant[1] = 20550; mant[2] = 16311;
        kind = int'(w[33:32]);
        tc   = int'(w[31:28]);
        if (kind == 3) begin
            d16 = w[27:12];
            eff = longint'(d16) * 512;
        end else if (mu) eff = 0;
        else eff = sx28(w[27:0]);
        diff = eff - cur;
        ad = (diff < 0) ? -diff : diff;
        nmag = mag;
        clr = 1'b0;
        case (kind)
            0: st = mant[tc % 3] >> (tc / 3);
            1: begin
                ac = (cur < 0) ? -cur : cur;
                st = ac >> (tc + 4);
                if (st == 0) st = 1;
            end
            2: begin
                st = ad >> (tc + 4);
                if (st == 0) st = 1;
            end
            default: begin
                if (w[31]) begin
                    st = ad >> ((tc % 8) + 6);
                    if (st == 0 && ad != 0) st = 1;
                    nmag = st;
                    clr = 1'b1;
                end else st = mag;
            end
        endcase
        if (ad <= st) ncur = eff;
        else if (diff < 0) ncur = cur - st;
        else ncur = cur + st;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 64; i++) begin
                m_tgt[i] <= {2'b00, 4'd5, 28'h0800000};
                m_cur[i] <= 64'h800000;
                m_mag[i] <= 0;
            end
            m_busy <= 1'b0; m_idx <= 0; m_done <= 1'b0; m_rd <= 64'h800000;
        end else begin
            m_rd   <= m_cur[rd_addr];
            m_done <= 1'b0;
            if (m_busy) begin
                longint nc, nm;
                bit cl;
                model_step(m_tgt[m_idx], m_cur[m_idx], m_mag[m_idx], mute, nc, nm, cl);
                m_cur[m_idx] <= nc;
                m_mag[m_idx] <= nm;
                if (cl) m_tgt[m_idx][31] <= 1'b0;
                if (m_idx == 63) begin
                    m_busy <= 1'b0; m_idx <= 0; m_done <= 1'b1;
                end else m_idx <= m_idx + 1;
            end else if (frame_start) begin
                m_busy <= 1'b1; m_idx <= 0;
            end
            if (wr_en) m_tgt[wr_addr] <= wr_data;
        end
    end

    // ---------------- checking ----------------
    task automatic check(input string tag, input longint act, input longint exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    bit     hold = 1'b0;
    logic [5:0] peek_addr = '0;
    logic [5:0] scan = '0;

    always @(negedge clk) begin
        if (!rst) begin
            check("R3 per-cycle rd_data", sx28(rd_data), m_rd);
            check("R2 per-cycle sweep_done", longint'(sweep_done), longint'(m_done));
        end
        scan    <= scan + 1'b1;
        rd_addr <= hold ? peek_addr : scan;
    end

    task automatic peek(input logic [5:0] a, input string tag, input longint exp);
        hold = 1'b1;
        peek_addr = a;
        @(negedge clk);
        @(negedge clk);
        #1;
        check(tag, sx28(rd_data), exp);
        hold = 1'b0;
    endtask

    task automatic write_word(input logic [5:0] a, input logic [33:0] w);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = w;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run_frames(input int n);
        for (int f = 0; f < n; f++) begin
            @(negedge clk); frame_start = 1'b1;
            @(negedge clk); frame_start = 1'b0;
            repeat (66) @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        misses++;
        $display("FAIL R2 watchdog expired actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        int cnt;
        int dones;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        peek(6'd0,  "R1 reset value loc0", 64'h800000);
        peek(6'd63, "R1 reset value loc63", 64'h800000);
        check("R1 done low after reset", longint'(sweep_done), 0);

        write_word(6'd0, {2'b00, 4'd0,  28'h0000000});
        write_word(6'd1, {2'b00, 4'd15, 28'h0000000});
        write_word(6'd2, {2'b01, 4'd2,  28'h0400000});
        write_word(6'd3, {2'b10, 4'd0,  28'hF800000});
        write_word(6'd4, {2'b11, 1'b1, 3'd0, 16'h2000, 12'hABC});

        // frame 1 with done timing (R2)
        @(negedge clk); frame_start = 1'b1;
        @(negedge clk); frame_start = 1'b0;
        cnt = 1;
        while (!sweep_done && cnt < 200) begin
            @(negedge clk); cnt++;
        end
        check("R2 done latency from start edge", cnt, 65);
        @(negedge clk);
        check("R2 done single pulse", longint'(sweep_done), 0);
        repeat (2) @(negedge clk);

        peek(6'd2, "R6 constant dB first step", 64'h7E0000);
        peek(6'd3, "R7 RC-style first step", 64'h700000);
        peek(6'd5, "R1 untouched location stays 1.0", 64'h800000);

        run_frames(9);
        peek(6'd1, "R5 linear tc15 after 10 frames", 8380518);
        run_frames(53);
        peek(6'd4, "R10 constant time after 63 frames", 64'h410000);
        run_frames(1);
        peek(6'd4, "R9 constant time target reached", 64'h400000);
        run_frames(323 - 64);
        peek(6'd0, "R5 linear tc0 after 323 frames", 25815);
        run_frames(1);
        peek(6'd0, "R8 linear lands on target", 0);
        run_frames(6);
        peek(6'd0, "R8 value holds at target", 0);

        // R11 mute
        @(negedge clk); mute = 1'b1;
        run_frames(1);
        peek(6'd5, "R11 muted linear ramps down", 8380453);
        peek(6'd4, "R11 constant time ignores mute", 64'h400000);
        @(negedge clk); mute = 1'b0;
        run_frames(1);
        peek(6'd5, "R11 release restores target", 64'h800000);

        // R4 / R12 collision at location 6, plus ignored start (R2)
        write_word(6'd6, {2'b11, 1'b1, 3'd0, 16'h0000, 12'h000});
        @(negedge clk); frame_start = 1'b1;
        @(negedge clk); frame_start = 1'b0;
        dones = 0;
        for (int c = 2; c <= 67; c++) begin
            @(negedge clk);
            if (sweep_done) dones++;
            wr_en = (c == 7);
            wr_addr = 6'd6;
            wr_data = {2'b11, 1'b1, 3'd1, 16'h1000, 12'h000};
            frame_start = (c == 12);
        end
        wr_en = 1'b0; frame_start = 1'b0;
        check("R2 start during sweep ignored", dones, 1);
        peek(6'd6, "R4 same-cycle visit uses old word", 64'h7E0000);
        run_frames(1);
        peek(6'd6, "R12 write kept its update flag", 64'h7D4400);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule